// File: doc/BRIEF.md
# Four-Mode Longword Shift Unit

This block is the shift stage of a small processor datapath. A 32-bit operand is moved left or right by a variable amount. Two operations fill with zeros. A third is a left shift that behaves the same as the zero-filling left shift. The fourth is a right shift that replicates the sign. The block also returns a carry flag that holds the last bit pushed out of the operand.

The shift amount comes from one of two sources, chosen per operation:
- **Register source.** The low six bits of a register value are used, so the amount is the value modulo 64.
- **Immediate source.** A 3-bit code from the instruction encodes an amount of 1 to 8.

Amounts of 32 or more saturate. Zero-fill modes return all zeros, and the sign-filling mode returns 32 copies of the sign bit.

The result and carry are available combinationally in the same cycle. A registered copy is also provided for paths with little timing slack.

Top module: `bshift_unit`

## Requirements
- R1: With `op_i` = 2'b00 (logical left), the result is the operand moved towards the MSB by the effective amount, and zeros enter at bit 0.
- R2: With `op_i` = 2'b01 (logical right), the result is the operand moved towards the LSB, and zeros enter at bit 31.
- R3: With `op_i` = 2'b11 (arithmetic right), the vacated upper bits take the value of the operand's bit 31, so bit 31 of the result always equals bit 31 of the operand.
- R4: With `op_i` = 2'b10 (arithmetic left), the result and carry equal those of the logical left shift for the same operand and amount.
- R5: With `imm_sel_i` = 0, the effective amount is `reg_cnt_i` modulo 64. Bits 31..6 of `reg_cnt_i` have no effect.
- R6: With `imm_sel_i` = 1, the effective amount comes from `imm_cnt_i`. Code 3'b000 means 8, and codes 3'b001..3'b111 mean 1..7. `reg_cnt_i` has no effect.
- R7: For effective amounts 32 to 63:
  - modes 00, 01 and 10 return 0;
  - mode 11 returns 32 copies of operand bit 31.
- R8: `carry_o` is the last bit moved out of the operand, which is 0 when only zeros were moved out. With an effective amount of 0, `carry_o` is 0 and the result equals the operand.
- R9: `res_q_o`/`carry_q_o` show the combinational result and carry one clock later. Both are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 32 | Operand to shift |
| op_i | input | 2 | Mode: 00 logical left, 01 logical right, 10 arithmetic left, 11 arithmetic right |
| imm_sel_i | input | 1 | 1 selects the immediate amount, 0 the register amount |
| reg_cnt_i | input | 32 | Register amount source (used modulo 64) |
| imm_cnt_i | input | 3 | Immediate amount code (000 means 8) |
| res_o | output | 32 | Combinational result |
| carry_o | output | 1 | Combinational carry-out |
| res_q_o | output | 32 | Registered result |
| carry_q_o | output | 1 | Registered carry-out |

## Verification
The hardest states to reach are at the saturation edges of the amount. These are:
- an amount of exactly 32, where the carry is still operand bit 0 or bit 31;
- amounts of 33 to 63, where the carry becomes the fill value;
- a register value whose high bits are set but whose low six bits are small.

A random register value almost never lands on these cases. The stimulus therefore uses directed vectors at amounts 0, 1, 31, 32, 33 and 63, and at immediate code 000. The random phase is biased so that about half of its register amounts fall in the range 28 to 63, with random upper bits above bit 5.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASL = 2'b10,
    SH_ASR = 2'b11
  } shop_e;

  localparam int unsigned AMT_W = 6;
  localparam int unsigned IMM_W = 3;
endpackage

// File: rtl/bshift_cnt_dec.sv
module bshift_cnt_dec
  import bshift_pkg::*;
#(
  parameter int unsigned RC_W = 32
) (
  input  logic              use_imm,
  input  logic [RC_W-1:0]   reg_cnt,
  input  logic [IMM_W-1:0]  imm_cnt,
  output logic [AMT_W-1:0]  amt
);
  localparam int unsigned IMM_FULL = 1 << IMM_W;

  logic [AMT_W-1:0] imm_amt;
  logic [AMT_W-1:0] reg_amt;

  // zero code stands for the largest immediate amount
  always_comb begin
    if (imm_cnt == '0) imm_amt = AMT_W'(IMM_FULL);
    else               imm_amt = AMT_W'(imm_cnt);
  end

  // register source is taken modulo 2**AMT_W
  assign reg_amt = reg_cnt[AMT_W-1:0];
  assign amt     = use_imm ? imm_amt : reg_amt;
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      data,
  input  logic              left,
  input  logic              arith,
  input  logic [AMT_W-1:0]  amt,
  output logic [W-1:0]      res,
  output logic              carry
);
  // one guard bit below the data catches the last bit shifted out
  localparam int unsigned EW = W + 1;

  logic [W-1:0]  fwd;
  logic          fill;
  logic [EW-1:0] stg [AMT_W+1];

  // left shifts run through the same right-shift network on reversed bits
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rev_in
      assign fwd[gi] = left ? data[W-1-gi] : data[gi];
    end
  endgenerate

  assign fill   = arith & ~left & data[W-1];
  assign stg[0] = {fwd, 1'b0};

  genvar gk;
  generate
    for (gk = 0; gk < AMT_W; gk++) begin : g_stage
      localparam int unsigned SH = 1 << gk;
      if (SH >= EW) begin : g_all_fill
        assign stg[gk+1] = amt[gk] ? {EW{fill}} : stg[gk];
      end else begin : g_part
        assign stg[gk+1] = amt[gk] ? {{SH{fill}}, stg[gk][EW-1:SH]} : stg[gk];
      end
    end
  endgenerate

  assign carry = stg[AMT_W][0];

  genvar go;
  generate
    for (go = 0; go < W; go++) begin : g_rev_out
      assign res[go] = left ? stg[AMT_W][W-go] : stg[AMT_W][go+1];
    end
  endgenerate
endmodule

// File: rtl/bshift_out_reg.sv
module bshift_out_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_res,
  input  logic         d_cy,
  output logic [W-1:0] q_res,
  output logic         q_cy
);
  logic [W-1:0] res_nxt;
  logic         cy_nxt;

  always_comb begin
    res_nxt = d_res;
    cy_nxt  = d_cy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_res <= '0;
      q_cy  <= 1'b0;
    end else begin
      q_res <= res_nxt;
      q_cy  <= cy_nxt;
    end
  end
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned RC_W    = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     opnd_i,
  input  logic [1:0]       op_i,
  input  logic             imm_sel_i,
  input  logic [RC_W-1:0]  reg_cnt_i,
  input  logic [IMM_W-1:0] imm_cnt_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o,
  output logic [W-1:0]     res_q_o,
  output logic             carry_q_o
);
  shop_e            op;
  logic             is_left;
  logic             is_arith;
  logic [AMT_W-1:0] amt;

  assign op       = shop_e'(op_i);
  assign is_left  = (op == SH_LSL) || (op == SH_ASL);
  assign is_arith = (op == SH_ASR);

  bshift_cnt_dec #(.RC_W(RC_W)) u_cnt (
    .use_imm (imm_sel_i),
    .reg_cnt (reg_cnt_i),
    .imm_cnt (imm_cnt_i),
    .amt     (amt)
  );

  bshift_core #(.W(W)) u_core (
    .data  (opnd_i),
    .left  (is_left),
    .arith (is_arith),
    .amt   (amt),
    .res   (res_o),
    .carry (carry_o)
  );

  generate
    if (REG_OUT) begin : g_reg
      bshift_out_reg #(.W(W)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_res (res_o),
        .d_cy  (carry_o),
        .q_res (res_q_o),
        .q_cy  (carry_q_o)
      );
    end else begin : g_bypass
      assign res_q_o   = res_o;
      assign carry_q_o = carry_o;
    end
  endgenerate
endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned RC_W    = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    opnd_i,
  input logic [1:0]      op_i,
  input logic            imm_sel_i,
  input logic [RC_W-1:0] reg_cnt_i,
  input logic [2:0]      imm_cnt_i,
  input logic [W-1:0]    res_o,
  input logic            carry_o,
  input logic [W-1:0]    res_q_o,
  input logic            carry_q_o
);
  logic reg_zero;
  logic reg_big;

  assign reg_zero = !imm_sel_i && (reg_cnt_i[5:0] == 6'd0);
  assign reg_big  = !imm_sel_i && reg_cnt_i[5];

  a_r8_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
    reg_zero |-> (res_o == opnd_i) && !carry_o);

  a_r7_sat_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_big && op_i == 2'b11) |-> res_o == {W{opnd_i[W-1]}});

  a_r7_sat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_big && op_i != 2'b11) |-> res_o == '0);

  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b11) |-> res_o[W-1] == opnd_i[W-1]);

  // R6: immediate amount is never zero, so a left shift always clears bit 0
  a_r6_imm_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_sel_i && !op_i[0]) |-> !res_o[0]);

  generate
    if (REG_OUT) begin : g_pipe_chk
      a_r9_reg_copy: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_q_o == $past(res_o)) && (carry_q_o == $past(carry_o)));
    end
  endgenerate
endmodule

bind bshift_unit bshift_unit_chk #(.W(W), .RC_W(RC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opnd_i    (opnd_i),
  .op_i      (op_i),
  .imm_sel_i (imm_sel_i),
  .reg_cnt_i (reg_cnt_i),
  .imm_cnt_i (imm_cnt_i),
  .res_o     (res_o),
  .carry_o   (carry_o),
  .res_q_o   (res_q_o),
  .carry_q_o (carry_q_o)
);

// File: tb/bshift_unit_tb.sv
module bshift_unit_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] opnd;
  logic [1:0]  op;
  logic        isel;
  logic [31:0] rcnt;
  logic [2:0]  icnt;
  logic [31:0] res, res_q;
  logic        cy, cy_q;

  int vec_cnt;
  int err_cnt;
  bit pend;
  logic [31:0] exp_q;
  logic        exp_cq;

  bshift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opnd_i(opnd), .op_i(op), .imm_sel_i(isel),
    .reg_cnt_i(rcnt), .imm_cnt_i(icnt), .res_o(res), .carry_o(cy),
    .res_q_o(res_q), .carry_q_o(cy_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural model: move one bit at a time, remember the last bit out
  function automatic logic [32:0] model(input logic [1:0] m, input logic [31:0] a,
                                        input int n);
    logic [31:0] v;
    logic        c;
    v = a;
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (m[0] == 1'b0) begin
        c = v[31];
        v = v << 1;
      end else begin
        c = v[0];
        v = (m == 2'b11) ? {v[31], v[31:1]} : (v >> 1);
      end
    end
    return {c, v};
  endfunction

  function automatic int eff_amt(input logic s, input logic [31:0] r, input logic [2:0] k);
    if (s) return (k == 3'd0) ? 8 : int'(k);
    return int'(r[5:0]);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    vec_cnt++;
    if (act !== expv) begin
      err_cnt++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] a, input logic s,
                       input logic [31:0] r, input logic [2:0] k, input string tag);
    logic [32:0] e;
    @(negedge clk);
    if (pend) begin
      check(res_q, exp_q, "R9 registered result");
      check({31'd0, cy_q}, {31'd0, exp_cq}, "R9 registered carry");
    end
    op = m; opnd = a; isel = s; rcnt = r; icnt = k;
    #5;
    e = model(m, a, eff_amt(s, r, k));
    check(res, e[31:0], tag);
    check({31'd0, cy}, {31'd0, e[32]}, {tag, " / R8 carry"});
    exp_q  = e[31:0];
    exp_cq = e[32];
    pend   = 1'b1;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    logic [1:0]  m;
    logic [31:0] r;
    string       tg;
    vec_cnt = 0; err_cnt = 0; pend = 1'b0;
    rst_n = 1'b0; op = 2'b00; opnd = 32'hDEAD_BEEF; isel = 1'b0; rcnt = 32'd5; icnt = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res_q, 32'd0, "R9 reset result");
    check({31'd0, cy_q}, 32'd0, "R9 reset carry");
    rst_n = 1'b1;

    // worked values
    apply(2'b01, 32'hF000_0003, 1'b1, 32'd0, 3'd1, "R2 lsr by 1");
    check(res, 32'h7800_0001, "R2 known value");
    apply(2'b00, 32'h7800_0001, 1'b0, 32'd4, 3'd0, "R1 lsl by 4");
    check(res, 32'h8000_0010, "R1 known value");
    apply(2'b11, 32'h8000_0003, 1'b1, 32'd0, 3'd5, "R3 asr by 5");
    check(res, 32'hFC00_0000, "R3 known value");
    apply(2'b10, 32'hFC00_0000, 1'b0, 32'd1, 3'd0, "R4 asl by 1");
    check(res, 32'hF800_0000, "R4 known value");

    // immediate decode: code 000 means 8, register value ignored
    apply(2'b01, 32'hFFFF_FFFF, 1'b1, 32'd3, 3'd0, "R6 code 000");
    check(res, 32'h00FF_FFFF, "R6 code 000 is 8");
    for (int k = 1; k < 8; k++)
      apply(2'b00, 32'h0000_0001, 1'b1, 32'd40, 3'(k), "R6 code 1..7");

    // register modulo 64: upper bits ignored
    apply(2'b01, 32'h8000_0000, 1'b0, 32'hFFFF_FFC3, 3'd0, "R5 mod 64");
    check(res, 32'h1000_0000, "R5 upper bits ignored");
    apply(2'b00, 32'h1234_5678, 1'b0, 32'h0000_0040, 3'd0, "R5 64 acts as 0");
    check(res, 32'h1234_5678, "R5 64 acts as 0 value");

    // saturation and amount-zero corners
    for (int mi = 0; mi < 4; mi++) begin
      m = 2'(mi);
      tg = (mi == 0) ? "R1" : (mi == 1) ? "R2" : (mi == 2) ? "R4" : "R3";
      apply(m, 32'h8000_0001, 1'b0, 32'd0,  3'd0, {tg, " R8 amount 0"});
      apply(m, 32'h8000_0001, 1'b0, 32'd31, 3'd0, {tg, " amount 31"});
      apply(m, 32'h8000_0001, 1'b0, 32'd32, 3'd0, {tg, " R7 amount 32"});
      apply(m, 32'h8000_0001, 1'b0, 32'd33, 3'd0, {tg, " R7 amount 33"});
      apply(m, 32'hC000_0002, 1'b0, 32'd63, 3'd0, {tg, " R7 amount 63"});
      apply(m, 32'h4000_0002, 1'b0, 32'd48, 3'd0, {tg, " R7 amount 48"});
    end

    // random phase, half the register amounts biased to 28..63
    for (int i = 0; i < 3000; i++) begin
      m = 2'($urandom_range(0, 3));
      r = $urandom;
      if (i[0]) r[5:0] = 6'($urandom_range(28, 63));
      tg = (m == 2'b00) ? "R1 random" : (m == 2'b01) ? "R2 random" :
           (m == 2'b10) ? "R4 random" : "R3 random";
      apply(m, $urandom, 1'($urandom_range(0, 1)), r, 3'($urandom_range(0, 7)), tg);
    end

    @(negedge clk);
    check(res_q, exp_q, "R9 registered result");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule